// File: doc/BRIEF.md
# Tree Reduce with Slot Accumulators

This block condenses a stream of four-lane signed integer flits into per-group scalar results. Each accepted flit first has its pad lanes replaced by the identity value of the selected operation. Its four lanes are then combined by a fixed two-level pairwise tree into one value. That value is folded into one of several independent accumulator slots. A slot is chosen per flit, so flits of different groups may arrive interleaved in time while each group keeps its own running result.

Every flit carries a valid-element count, a slot index and two markers. The first marker starts a group and the last marker ends it. Saturating add, maximum and minimum are selected by a run-wide operation input, which may only change while no group is open. A result appears on the output only when the last flit of its group has been folded in. A slot index beyond the available slots marks an illegal mapping. Such a flit is reported on an error output and otherwise discarded. The block accepts one flit on every clock.

Top module: `tree_slot_reduce`

## Requirements
- R1: Lane k occupies bits [32k+31:32k] of `in_lanes`, and the tree result is op(op(lane0, lane1), op(lane2, lane3)) evaluated in exactly that grouping.
- R2: `op_sel` code 0 selects saturating add (identity 0), code 1 selects signed maximum (identity -2^31), and code 2 selects signed minimum (identity 2^31-1).
- R3: Saturating add clamps every partial sum to the range [-2^31, 2^31-1], both inside the tree and when adding into a slot.
- R4: A lane whose index is not less than `in_count` is replaced by the identity value. A count of 0 makes the flit contribute only the identity, and a count of 4 or more keeps all lanes.
- R5: A flit with `in_first`=1 loads its slot with its tree result. A flit with `in_first`=0 combines its tree result with the slot's current contents.
- R6: The 8 slots are independent: flits to one slot never alter another slot's result, whatever the interleaving.
- R7: A legal flit with `in_last`=1 makes `out_valid` high for one cycle two clocks after it is sampled, with the group's final value on `out_data` and its slot on `out_slot`. A flit with `in_first` and `in_last` both set gives its own result. No other flit and no idle cycle produce an output.
- R8: A flit with `in_slot` of 8 or more raises `out_err` for one cycle two clocks later, produces no `out_valid`, and changes no slot.
- R9: Flits are accepted on every clock, including back-to-back flits to the same slot, with no loss and no stall.
- R10: While `rst` is high, and in the first cycle after it, `out_valid` and `out_err` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 2 | Operation code: 0 add-sat, 1 max, 2 min |
| in_valid | input | 1 | Flit present this cycle |
| in_lanes | input | 128 | Four 32-bit signed lanes, lane 0 in the low bits |
| in_count | input | 3 | Number of valid lanes starting from lane 0 |
| in_slot | input | 4 | Accumulator slot index; 8 or more is illegal |
| in_first | input | 1 | Flit opens its group |
| in_last | input | 1 | Flit closes its group |
| out_valid | output | 1 | Group result present |
| out_data | output | 32 | Final group value |
| out_slot | output | 3 | Slot the result belongs to |
| out_err | output | 1 | Illegal slot index seen two clocks earlier |

## Verification
The bench builds the block with its default values: 32-bit lanes and 8 slots. At that size every valid count from 0 to 7 can be swept under all three operations, and every slot, including the whole illegal range 8 to 15, can be reached within one random stream. Lane values are drawn with a strong bias toward the two 32-bit extremes. This exercises tree-level and accumulator-level saturation often, as well as the identity boundaries for max and min. Long interleaved streams with back-to-back hits on the same slot test slot independence at full rate.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  localparam int LANES = 4;

  typedef enum logic [1:0] {
    OP_SADD = 2'd0,
    OP_MAX  = 2'd1,
    OP_MIN  = 2'd2,
    OP_RSVD = 2'd3
  } red_op_e;
endpackage

// File: rtl/tsr_alu.sv
module tsr_alu #(
  parameter int W = 32
) (
  input  tsr_pkg::red_op_e   op,
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] y
);
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic signed [W:0] sum;
  assign sum = {a[W-1], a} + {b[W-1], b};

  always_comb begin
    case (op)
      tsr_pkg::OP_MAX: y = (a > b) ? a : b;
      tsr_pkg::OP_MIN: y = (a < b) ? a : b;
      default: begin
        if (sum[W] != sum[W-1]) y = sum[W] ? MINV : MAXV;
        else                    y = sum[W-1:0];
      end
    endcase
  end
endmodule

// File: rtl/tsr_lane_tree.sv
module tsr_lane_tree #(
  parameter int W     = 32,
  parameter int SLOTS = 8,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int SEL_W = IDX_W + 1,
  localparam int CNT_W = $clog2(tsr_pkg::LANES + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  tsr_pkg::red_op_e              op,
  input  logic                          in_valid,
  input  logic [tsr_pkg::LANES*W-1:0]   in_lanes,
  input  logic [CNT_W-1:0]              in_count,
  input  logic [SEL_W-1:0]              in_slot,
  input  logic                          in_first,
  input  logic                          in_last,
  output logic                          s1_valid,
  output logic                          s1_err,
  output logic signed [W-1:0]           s1_data,
  output logic [IDX_W-1:0]              s1_slot,
  output logic                          s1_first,
  output logic                          s1_last
);
  localparam int HALF = tsr_pkg::LANES / 2;
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic signed [W-1:0] ident;
  logic signed [W-1:0] masked [tsr_pkg::LANES];
  logic signed [W-1:0] lvl1   [HALF];
  logic signed [W-1:0] root;
  logic                legal;

  always_comb begin
    case (op)
      tsr_pkg::OP_MAX: ident = MINV;
      tsr_pkg::OP_MIN: ident = MAXV;
      default:         ident = '0;
    endcase
  end

  for (genvar i = 0; i < tsr_pkg::LANES; i++) begin : g_mask
    assign masked[i] = (in_count > CNT_W'(i)) ? in_lanes[i*W +: W] : ident;
  end

  for (genvar p = 0; p < HALF; p++) begin : g_lvl1
    tsr_alu #(.W(W)) u_alu (.op(op), .a(masked[2*p]), .b(masked[2*p+1]), .y(lvl1[p]));
  end

  tsr_alu #(.W(W)) u_root (.op(op), .a(lvl1[0]), .b(lvl1[1]), .y(root));

  assign legal = (in_slot < SEL_W'(SLOTS));

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_err   <= 1'b0;
    end else begin
      s1_valid <= in_valid & legal;
      s1_err   <= in_valid & ~legal;
    end
    s1_data  <= root;
    s1_slot  <= in_slot[IDX_W-1:0];
    s1_first <= in_first;
    s1_last  <= in_last;
  end

  // R4: a zero count under max leaves only the identity in the tree
  a_r4_zero_count: assert property (@(posedge clk) disable iff (rst)
    (in_valid && legal && in_count == '0 && op == tsr_pkg::OP_MAX) |=> (s1_data == MINV));
endmodule

// File: rtl/tsr_slot_acc.sv
module tsr_slot_acc #(
  parameter int W     = 32,
  parameter int SLOTS = 8,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  tsr_pkg::red_op_e     op,
  input  logic                 s1_valid,
  input  logic                 s1_err,
  input  logic signed [W-1:0]  s1_data,
  input  logic [IDX_W-1:0]     s1_slot,
  input  logic                 s1_first,
  input  logic                 s1_last,
  output logic                 out_valid,
  output logic signed [W-1:0]  out_data,
  output logic [IDX_W-1:0]     out_slot,
  output logic                 out_err
);
  logic signed [W-1:0] mem [SLOTS];
  logic signed [W-1:0] old_val;
  logic signed [W-1:0] merged;
  logic signed [W-1:0] nxt;

  assign old_val = mem[s1_slot];

  tsr_alu #(.W(W)) u_fold (.op(op), .a(old_val), .b(s1_data), .y(merged));

  assign nxt = s1_first ? s1_data : merged;

  always_ff @(posedge clk) begin
    if (s1_valid) mem[s1_slot] <= nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= s1_valid & s1_last;
      out_err   <= s1_err;
    end
    out_data <= nxt;
    out_slot <= s1_slot;
  end

  // R5: a continuing max group never falls below either operand
  a_r5_max_monotone: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_last && !s1_first && op == tsr_pkg::OP_MAX)
      |=> (out_data >= $past(old_val) && out_data >= $past(s1_data)));

  // R8: an error report never coincides with a result
  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_err));
endmodule

// File: rtl/tree_slot_reduce.sv
module tree_slot_reduce #(
  parameter int W     = 32,
  parameter int SLOTS = 8,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int SEL_W = IDX_W + 1,
  localparam int CNT_W = $clog2(tsr_pkg::LANES + 1)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [1:0]                   op_sel,
  input  logic                         in_valid,
  input  logic [tsr_pkg::LANES*W-1:0]  in_lanes,
  input  logic [CNT_W-1:0]             in_count,
  input  logic [SEL_W-1:0]             in_slot,
  input  logic                         in_first,
  input  logic                         in_last,
  output logic                         out_valid,
  output logic [W-1:0]                 out_data,
  output logic [IDX_W-1:0]             out_slot,
  output logic                         out_err
);
  tsr_pkg::red_op_e op;
  logic                s1_valid, s1_err, s1_first, s1_last;
  logic signed [W-1:0] s1_data;
  logic [IDX_W-1:0]    s1_slot;
  logic signed [W-1:0] res;

  assign op = tsr_pkg::red_op_e'(op_sel);

  tsr_lane_tree #(.W(W), .SLOTS(SLOTS)) u_tree (
    .clk(clk), .rst(rst), .op(op),
    .in_valid(in_valid), .in_lanes(in_lanes), .in_count(in_count),
    .in_slot(in_slot), .in_first(in_first), .in_last(in_last),
    .s1_valid(s1_valid), .s1_err(s1_err), .s1_data(s1_data),
    .s1_slot(s1_slot), .s1_first(s1_first), .s1_last(s1_last)
  );

  tsr_slot_acc #(.W(W), .SLOTS(SLOTS)) u_acc (
    .clk(clk), .rst(rst), .op(op),
    .s1_valid(s1_valid), .s1_err(s1_err), .s1_data(s1_data),
    .s1_slot(s1_slot), .s1_first(s1_first), .s1_last(s1_last),
    .out_valid(out_valid), .out_data(res), .out_slot(out_slot), .out_err(out_err)
  );

  assign out_data = res;

  // R7: a legal closing flit yields a result on its own slot two clocks later
  a_r7_latency: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_slot < SEL_W'(SLOTS) && in_last)
      |-> ##2 (out_valid && out_slot == $past(in_slot[IDX_W-1:0], 2)));

  // R7: an idle cycle produces nothing two clocks later
  a_r7_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 (!out_valid && !out_err));

  // R8: an illegal slot index is flagged and yields no result
  a_r8_bad_slot: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_slot >= SEL_W'(SLOTS)) |-> ##2 (out_err && !out_valid));
endmodule

// File: tb/sim_tree_slot_reduce.sv
module sim_tree_slot_reduce;
  localparam int PERIOD = 10;
  localparam int W      = 32;
  localparam int SLOTS  = 8;
  localparam logic signed [31:0] MAXV = 32'h7fff_ffff;
  localparam logic signed [31:0] MINV = 32'h8000_0000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   op_sel = 2'd0;
  logic         in_valid = 1'b0;
  logic [127:0] in_lanes = '0;
  logic [2:0]   in_count = '0;
  logic [3:0]   in_slot = '0;
  logic         in_first = 1'b0;
  logic         in_last = 1'b0;
  logic         out_valid;
  logic [31:0]  out_data;
  logic [2:0]   out_slot;
  logic         out_err;

  always #(PERIOD/2) clk = ~clk;

  tree_slot_reduce #(.W(W), .SLOTS(SLOTS)) u0 (
    .clk(clk), .rst(rst), .op_sel(op_sel), .in_valid(in_valid),
    .in_lanes(in_lanes), .in_count(in_count), .in_slot(in_slot),
    .in_first(in_first), .in_last(in_last), .out_valid(out_valid),
    .out_data(out_data), .out_slot(out_slot), .out_err(out_err)
  );

  int checks = 0;
  int fails  = 0;

  bit          p1v = 0, p1e = 0, p2v = 0, p2e = 0;
  logic [31:0] p1d = '0, p2d = '0;
  logic [2:0]  p1s = '0, p2s = '0;
  string       p1t = "R10", p2t = "R10";

  logic signed [31:0] racc [SLOTS];
  bit                 open_s [SLOTS];
  int                 cur_op = 0;

  function automatic logic signed [31:0] rf(int op, logic signed [31:0] a, logic signed [31:0] b);
    longint s;
    if (op == 1) return (a > b) ? a : b;
    if (op == 2) return (a < b) ? a : b;
    s = longint'(a) + longint'(b);
    if (s > longint'(MAXV)) return MAXV;
    if (s < longint'(MINV)) return MINV;
    return s[31:0];
  endfunction

  function automatic logic signed [31:0] rid(int op);
    if (op == 1) return MINV;
    if (op == 2) return MAXV;
    return 32'sd0;
  endfunction

  function automatic logic [31:0] rval();
    case ($urandom % 5)
      0: return MAXV;
      1: return MINV;
      2: return $urandom % 16;
      default: return $urandom;
    endcase
  endfunction

  function automatic logic [127:0] rlanes();
    return {rval(), rval(), rval(), rval()};
  endfunction

  task automatic step(bit v, logic [3:0] slot, bit f, bit l, logic [2:0] cnt,
                      logic [127:0] lanes, string tag);
    logic signed [31:0] m [4];
    logic signed [31:0] t;
    bit nv, ne;
    logic [31:0] nd;
    @(negedge clk);
    checks++;
    if (out_valid !== p2v || out_err !== p2e || (p2v && (out_data !== p2d || out_slot !== p2s))) begin
      fails++;
      $display("FAIL %s: got v=%0b e=%0b d=%h s=%0d, expected v=%0b e=%0b d=%h s=%0d",
               p2t, out_valid, out_err, out_data, out_slot, p2v, p2e, p2d, p2s);
    end
    nv = 0; ne = 0; nd = '0;
    if (v) begin
      if (slot >= 4'(SLOTS)) ne = 1;
      else begin
        for (int k = 0; k < 4; k++) m[k] = (int'(cnt) > k) ? lanes[k*32 +: 32] : rid(cur_op);
        t = rf(cur_op, rf(cur_op, m[0], m[1]), rf(cur_op, m[2], m[3]));
        racc[slot[2:0]] = f ? t : rf(cur_op, racc[slot[2:0]], t);
        open_s[slot[2:0]] = !l;
        if (l) begin nv = 1; nd = racc[slot[2:0]]; end
      end
    end
    p2v = p1v; p2e = p1e; p2d = p1d; p2s = p1s; p2t = p1t;
    p1v = nv;  p1e = ne;  p1d = nd;  p1s = slot[2:0]; p1t = tag;
    in_valid = v; in_slot = slot; in_first = f; in_last = l;
    in_count = cnt; in_lanes = lanes;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 4'd0, 0, 0, 3'd0, '0, "R7");
  endtask

  task automatic close_all();
    for (int s = 0; s < SLOTS; s++)
      if (open_s[s]) step(1, 4'(s), 0, 1, 3'd4, rlanes(), "R6");
    idle(3);
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: got hang, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < SLOTS; s++) begin racc[s] = '0; open_s[s] = 0; end
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_err !== 1'b0) begin
      fails++;
      $display("FAIL R10: got v=%0b e=%0b, expected v=0 e=0", out_valid, out_err);
    end
    rst = 1'b0;
    idle(2);

    for (int op = 0; op < 3; op++) begin
      cur_op = op;
      op_sel = 2'(op);
      idle(1);
      // R2 R4: count sweep on single-flit groups
      for (int c = 0; c < 8; c++)
        for (int r = 0; r < 6; r++)
          step(1, 4'((c + r) % SLOTS), 1, 1, 3'(c), rlanes(), "R4");
      // R1: grouping matters for saturating add
      step(1, 4'd3, 1, 1, 3'd4, {32'sd0, MINV, 32'sd1, MAXV}, "R1");
      step(1, 4'd4, 1, 1, 3'd4, {MINV, MINV, MAXV, MAXV}, "R1");
      // R5 R6: interleaved pattern 0,0,1,1,0,0,1,1
      step(1, 4'd0, 1, 0, 3'd4, rlanes(), "R6");
      step(1, 4'd0, 0, 0, 3'd3, rlanes(), "R6");
      step(1, 4'd1, 1, 0, 3'd4, rlanes(), "R6");
      step(1, 4'd1, 0, 0, 3'd2, rlanes(), "R6");
      step(1, 4'd0, 0, 0, 3'd4, rlanes(), "R5");
      step(1, 4'd0, 0, 1, 3'd1, rlanes(), "R5");
      step(1, 4'd1, 0, 0, 3'd4, rlanes(), "R5");
      step(1, 4'd1, 0, 1, 3'd4, rlanes(), "R5");
      idle(2);
      // R3: accumulator saturation
      step(1, 4'd2, 1, 0, 3'd1, {96'd0, MAXV}, "R3");
      step(1, 4'd2, 0, 1, 3'd1, {96'd0, 32'sd1}, "R3");
      step(1, 4'd5, 1, 0, 3'd4, {MINV, MINV, MINV, MINV}, "R3");
      step(1, 4'd5, 0, 1, 3'd4, {MINV, 32'sd0, 32'sd0, 32'sd0}, "R3");
      // R8: illegal slot between two flits of one group
      step(1, 4'd6, 1, 0, 3'd4, rlanes(), "R8");
      for (int b = 8; b < 16; b++) step(1, 4'(b), 1, 1, 3'd4, rlanes(), "R8");
      step(1, 4'd6, 0, 1, 3'd4, rlanes(), "R8");
      // R9: back-to-back same slot at full rate
      step(1, 4'd7, 1, 0, 3'd4, rlanes(), "R9");
      for (int r = 0; r < 10; r++) step(1, 4'd7, 0, r == 9, 3'd4, rlanes(), "R9");
      // R6 R7 R9: random interleaved stream
      for (int r = 0; r < 400; r++) begin
        int pick;
        int s;
        pick = $urandom % 10;
        s = $urandom % SLOTS;
        if (pick == 0) step(0, 4'd0, 0, 0, 3'd0, '0, "R7");
        else if (pick == 1) step(1, 4'(8 + $urandom % 8), $urandom % 2, $urandom % 2, 3'd4, rlanes(), "R8");
        else step(1, 4'(s), !open_s[s], ($urandom % 3) == 0, 3'($urandom % 6), rlanes(), "R6");
      end
      close_all();
    end
    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule